// File: doc/BRIEF.md
# Sparse-Matrix Parallel Random Bit Generator

This block produces six uniformly distributed pseudo-random bits on every enabled clock. Its next state is a fixed sparse binary matrix applied to the whole current state at once. Each next-state bit is the exclusive-or of either two or three current-state bits, so every bit costs one small lookup function and one flip-flop. One clock therefore yields a full fresh word through a single level of logic. A single-tap shift chain, by contrast, shifts in one new bit per clock.

The state is presented unchanged on the output. The matrix is chosen so that the sequence has the maximum period of 63 and passes through every nonzero six-bit pattern once before it repeats. The all-zero pattern maps to itself and would lock the generator. For that reason the block never enters it: reset and zero seeds both select a fixed nonzero default.

The user seeds the whole state in one clock through a parallel load port. Between loads, the user advances the sequence with a plain step enable. When the consumer is not ready, it drops the enable, and the output word holds for as long as the enable stays low. This gives back-pressure without a separate handshake.

Top module: `sparse_xor_rng`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `rnd_out` equals the default seed 6'b000001.
- R2: Bit k of `rnd_out` is state bit x(k+1), so `rnd_out[0]` is x1 and `rnd_out[5]` is x6. When `step_en` is 1 and `load_en` is 0 at a rising edge, the state after that edge is as follows. x1 = x2^x3. x2 = x2^x3^x6. x3 = x2^x4. x4 = x1^x5. x5 = x1^x6. x6 = x1^x4^x5.
- R3: When both `load_en` and `step_en` are 0 at a rising edge, `rnd_out` keeps its value.
- R4: When `load_en` is 1 and `load_seed` is nonzero at a rising edge, `rnd_out` equals `load_seed` after that edge, whatever the value of `step_en`.
- R5: When `load_en` is 1 and `load_seed` is 6'b000000 at a rising edge, `rnd_out` becomes 6'b000001.
- R6: `rnd_out` is never 6'b000000 outside reset.
- R7: Starting from any nonzero seed, 63 consecutive steps return `rnd_out` to that seed. No value repeats within those steps, and the values visited are all 63 nonzero patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Parallel seed load; takes priority over stepping |
| load_seed | input | 6 | Seed value; zero is replaced by 6'b000001 |
| step_en | input | 1 | Advance the sequence by one matrix step |
| rnd_out | output | 6 | Current state, used directly as the random word |

## Verification
A behavioural model of the six equations runs alongside the design and is compared every clock. This catches a miswired tap, which would shift the sequence at the first step. The bench walks full periods from two different seeds. A matrix that is not maximal would repeat a value early or fail to return to the seed after 63 steps.

Load is driven together with the step enable to expose a priority inversion, which would show up as a stepped value in place of the seed. A zero seed is loaded to catch a design that accepts it literally and then freezes at zero. Idle gaps are mixed into the stepping to catch a design that advances without the enable.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int RNG_W = 6;
  localparam logic [RNG_W-1:0] RNG_DEFAULT_SEED = 6'b000001;
  // Row r of the transition matrix: bit c set means state bit c feeds next bit r.
  localparam logic [RNG_W-1:0] RNG_ROW_MASK [RNG_W] = '{
    6'b000110,  // next bit 0
    6'b100110,  // next bit 1
    6'b001010,  // next bit 2
    6'b010001,  // next bit 3
    6'b100001,  // next bit 4
    6'b011001   // next bit 5
  };
endpackage

// File: rtl/sparse_xor_matrix.sv
module sparse_xor_matrix
  import rng_pkg::*;
#(
  parameter int W = RNG_W
) (
  input  logic [W-1:0] cur_state,
  output logic [W-1:0] nxt_state
);
  for (genvar row = 0; row < W; row++) begin : g_row
    assign nxt_state[row] = ^(cur_state & RNG_ROW_MASK[row]);
  end
endmodule

// File: rtl/rng_state_reg.sv
module rng_state_reg
  import rng_pkg::*;
#(
  parameter int W = RNG_W,
  parameter logic [W-1:0] DEFAULT_SEED = RNG_DEFAULT_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_seed,
  input  logic         step_en,
  input  logic [W-1:0] step_value,
  output logic [W-1:0] state_q
);
  logic [W-1:0] seed_safe;
  logic         seed_is_zero;

  assign seed_is_zero = (load_seed == '0);
  assign seed_safe    = seed_is_zero ? DEFAULT_SEED : load_seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= DEFAULT_SEED;
    else if (load_en)  state_q <= seed_safe;
    else if (step_en)  state_q <= step_value;
  end
endmodule

// File: rtl/sparse_xor_rng.sv
module sparse_xor_rng
  import rng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [RNG_W-1:0] load_seed,
  input  logic             step_en,
  output logic [RNG_W-1:0] rnd_out
);
  logic [RNG_W-1:0] state_q;
  logic [RNG_W-1:0] state_nxt;

  sparse_xor_matrix #(.W(RNG_W)) u_matrix (
    .cur_state (state_q),
    .nxt_state (state_nxt)
  );

  rng_state_reg #(.W(RNG_W), .DEFAULT_SEED(RNG_DEFAULT_SEED)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_seed  (load_seed),
    .step_en    (step_en),
    .step_value (state_nxt),
    .state_q    (state_q)
  );

  assign rnd_out = state_q;
endmodule

// File: rtl/sparse_xor_rng_chk.sv
module sparse_xor_rng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_en,
  input logic [5:0] load_seed,
  input logic       step_en,
  input logic [5:0] rnd_out
);
  assert_step_eqn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && step_en) |=> rnd_out == {
      $past(rnd_out[0]) ^ $past(rnd_out[3]) ^ $past(rnd_out[4]),
      $past(rnd_out[0]) ^ $past(rnd_out[5]),
      $past(rnd_out[0]) ^ $past(rnd_out[4]),
      $past(rnd_out[1]) ^ $past(rnd_out[3]),
      $past(rnd_out[1]) ^ $past(rnd_out[2]) ^ $past(rnd_out[5]),
      $past(rnd_out[1]) ^ $past(rnd_out[2])});

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(rnd_out));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_seed != 6'd0) |=> rnd_out == $past(load_seed));

  assert_zero_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_seed == 6'd0) |=> rnd_out == 6'b000001);

  assert_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_out != 6'd0);
endmodule

bind sparse_xor_rng sparse_xor_rng_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .load_seed (load_seed),
  .step_en   (step_en),
  .rnd_out   (rnd_out)
);

// File: tb/sparse_xor_rng_bench.sv
module sparse_xor_rng_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [5:0] load_seed = 6'd0;
  logic       step_en = 1'b0;
  logic [5:0] rnd_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int model;

  always #2 clk = ~clk;

  sparse_xor_rng u_sparse_xor_rng (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .load_seed(load_seed), .step_en(step_en), .rnd_out(rnd_out)
  );

  function automatic int bitv(int v, int k);
    return (v >> (k - 1)) & 1;
  endfunction

  function automatic int advance(int v);
    int r;
    r = 0;
    r += (bitv(v,2) ^ bitv(v,3)) * 1;
    r += (bitv(v,2) ^ bitv(v,3) ^ bitv(v,6)) * 2;
    r += (bitv(v,2) ^ bitv(v,4)) * 4;
    r += (bitv(v,1) ^ bitv(v,5)) * 8;
    r += (bitv(v,1) ^ bitv(v,6)) * 16;
    r += (bitv(v,1) ^ bitv(v,4) ^ bitv(v,5)) * 32;
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply inputs, update model, clock, then compare away from the edge.
  task automatic tick(bit ld, int seed, bit st, string req);
    load_en = ld; load_seed = seed[5:0]; step_en = st;
    if (ld) model = (seed == 0) ? 1 : seed;
    else if (st) model = advance(model);
    @(posedge clk); #1;
    check(int'(rnd_out) == model, req, rnd_out, model);
    check(rnd_out != 6'd0, "R6", rnd_out, 1);
  endtask

  task automatic period_run(int seed);
    bit seen [64];
    int distinct;
    for (int i = 0; i < 64; i++) seen[i] = 1'b0;
    tick(1'b1, seed, 1'b0, "R4");
    distinct = 0;
    for (int s = 1; s <= 63; s++) begin
      tick(1'b0, 0, 1'b1, "R2");
      if (s < 63) check(int'(rnd_out) != seed && !seen[rnd_out], "R7", rnd_out, seed);
      else        check(int'(rnd_out) == seed, "R7", rnd_out, seed);
      if (!seen[rnd_out]) distinct++;
      seen[rnd_out] = 1'b1;
    end
    check(distinct == 63 && !seen[0], "R7", distinct, 63);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model = 1;
    repeat (3) @(posedge clk);
    #1;
    check(rnd_out == 6'b000001, "R1", rnd_out, 1);
    rst_n = 1'b1;
    #1;
    check(rnd_out == 6'b000001, "R1", rnd_out, 1);
    for (int i = 0; i < 3; i++) tick(1'b0, 0, 1'b0, "R3");
    for (int i = 0; i < 20; i++) tick(1'b0, 0, 1'b1, "R2");
    tick(1'b1, 6'h15, 1'b1, "R4");
    tick(1'b0, 0, 1'b0, "R3");
    tick(1'b1, 0, 1'b1, "R5");
    tick(1'b1, 6'h3E, 1'b0, "R4");
    tick(1'b1, 0, 1'b0, "R5");
    for (int i = 0; i < 40; i++) tick(1'b0, 0, (i % 3) != 1, "R3");
    period_run(6'h2A);
    period_run(6'h3F);
    period_run(6'h01);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule